// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM auto-refresh has to be issued and drives the short command sequence that performs it. Two sources can ask for a refresh. The first is a free-running interval timer set just under the retention budget of one row: 770 cycles at 100 MHz, which is 7.7 us against a 7.8 us limit. The second is a manual request that the access logic may raise after any completed read or write. Both sources feed one sticky pending flag. A manual request that is accepted restarts the interval timer, so an early refresh never leads to a second, redundant one shortly after.

The command sequencer sees the pending flag as `rf_need` and answers with `seq_grant` once the command bus is free. If a row is open at that point, the scheduler first closes all banks with a precharge, waits the row-precharge time and then issues AUTO REFRESH. If no row is open, it issues AUTO REFRESH at once. From the first command until the refresh window closes, `busy` stays high and only NOP appears on the command lines. No row or column address is driven, because the device supplies the refresh row itself. The worst-case in-flight access plus this sequence is expected to fit within the 7.8 us budget.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is low, and in the first cycle after it, `cmd_code` is NOP (4'b0111), `cmd_a10`, `busy` and `rf_need` are 0.
- R2: With no accepted manual request, `rf_need` rises exactly INTERVAL_CYC (770) clock edges after the last interval restart, and not earlier.
- R3: A `refresh_req` sampled while the scheduler is idle and nothing is pending raises `rf_need` after that edge and restarts the interval count from that edge.
- R4: A `refresh_req` sampled while a refresh is pending or in progress has no effect and does not restart the interval. A request that lands on the edge where the interval expires produces a single refresh.
- R5: `seq_grant` sampled while idle with `rf_need` high starts the sequence in the next cycle and clears `rf_need`. `seq_grant` with nothing pending has no effect.
- R6: If `row_open` is high when the grant is taken, the first command is PRECHARGE (4'b0010) with `cmd_a10` high. It is followed by NOPs, and AUTO REFRESH comes exactly TRP_CYC (2) cycles after the PRECHARGE.
- R7: If `row_open` is low when the grant is taken, AUTO REFRESH (4'b0001) appears in the cycle right after the grant edge.
- R8: `busy` is high from the first command of the sequence through the TRFC_CYC (9) cycle window that starts with AUTO REFRESH, and low in the cycle after that window. Only NOP is issued inside the window after the AUTO REFRESH.
- R9: `cmd_code` is always one of NOP, PRECHARGE or AUTO REFRESH, in {CS_n, RAS_n, CAS_n, WE_n} order, and `cmd_a10` is high only with PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_req | input | 1 | Manual refresh request from the access logic |
| row_open | input | 1 | High when any bank holds an open row |
| seq_grant | input | 1 | Sequencer hands the command bus to the scheduler |
| rf_need | output | 1 | A refresh is pending (sticky until granted) |
| busy | output | 1 | Refresh sequence owns the command bus |
| cmd_code | output | 4 | Command as {CS_n, RAS_n, CAS_n, WE_n} |
| cmd_a10 | output | 1 | Address bit 10, high for precharge of all banks |

## Verification
The hardest case to reach is a manual request that arrives on exactly the edge where the interval timer expires, because the timer phase is invisible at the ports. The bench therefore tracks every interval restart itself: it times one accepted request and one natural expiry, and from them derives the expiry edge of the following interval. It then places a request on that edge and expects exactly one `rf_need` rise and one AUTO REFRESH. A scoreboard flags any extra event, so a request that wrongly restarts the timer while a refresh is pending or running shows up as an event at an unexpected cycle.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int INTERVAL_CYC = 770,
  parameter int TRP_CYC      = 2,
  parameter int TRFC_CYC     = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh_req,
  input  logic       row_open,
  input  logic       seq_grant,
  output logic       rf_need,
  output logic       busy,
  output logic [3:0] cmd_code,
  output logic       cmd_a10
);
  // TRP_CYC and TRFC_CYC must be at least 2.
  localparam int CW = $clog2(INTERVAL_CYC);
  localparam int WW = $clog2((TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC) + 1;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_TRP, S_REF, S_RFC} st_t;

  st_t           st;
  logic [CW-1:0] ivl;
  logic [WW-1:0] wcnt;
  logic          pend;
  logic          idle, expire, req_ok, take;

  assign idle   = (st == S_IDLE);
  assign expire = (ivl == CW'(INTERVAL_CYC - 1));
  assign req_ok = refresh_req & idle & ~pend;
  assign take   = seq_grant & idle & pend;

  always_ff @(posedge clk) begin
    if (!rst_n)                ivl <= '0;
    else if (expire || req_ok) ivl <= '0;
    else                       ivl <= ivl + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~take) | expire | req_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wcnt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (take) st <= row_open ? S_PRE : S_REF;
        S_PRE: begin
          st   <= S_TRP;
          wcnt <= WW'(TRP_CYC - 2);
        end
        S_TRP:
          if (wcnt == '0) st <= S_REF;
          else            wcnt <= wcnt - 1'b1;
        S_REF: begin
          st   <= S_RFC;
          wcnt <= WW'(TRFC_CYC - 2);
        end
        S_RFC:
          if (wcnt == '0) st <= S_IDLE;
          else            wcnt <= wcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rf_need  = pend;
  assign busy     = ~idle;
  assign cmd_a10  = (st == S_PRE);
  assign cmd_code = (st == S_PRE) ? CMD_PRE :
                    (st == S_REF) ? CMD_REF : CMD_NOP;

  logic [WW-1:0] chk_left;
  always_ff @(posedge clk) begin
    if (!rst_n)                   chk_left <= '0;
    else if (cmd_code == CMD_REF) chk_left <= WW'(TRFC_CYC - 1);
    else if (chk_left != '0)      chk_left <= chk_left - 1'b1;
  end

  // R8
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_left != '0) |-> (cmd_code == CMD_NOP && busy));

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_left == WW'(1)) |=> !busy);

  // R9
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_NOP || cmd_code == CMD_PRE || cmd_code == CMD_REF));

  // R9
  a10_only_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a10 |-> (cmd_code == CMD_PRE));

  // R6
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |=> (cmd_code == CMD_NOP && busy));

  // R5
  start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rf_need && seq_grant));

  // R5
  need_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!rf_need || $past(expire)));
endmodule

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PRE  = 4'b0010;
  localparam logic [3:0] AREF = 4'b0001;
  localparam logic [3:0] NEED = 4'b1000;
  localparam int IVL = 770;

  logic clk = 1'b0;
  logic rst_n, refresh_req, row_open, seq_grant;
  logic rf_need, busy, cmd_a10;
  logic [3:0] cmd_code;

  always #4 clk = ~clk;

  sdram_refresh_sched i_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .row_open(row_open),
    .seq_grant(seq_grant), .rf_need(rf_need), .busy(busy),
    .cmd_code(cmd_code), .cmd_a10(cmd_a10)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          exp_cyc[$];
  logic [3:0]  exp_kind[$];
  string       exp_tag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(input int c, input logic [3:0] k, input string tag);
    exp_cyc.push_back(c);
    exp_kind.push_back(k);
    exp_tag.push_back(tag);
  endtask

  task automatic observe(input logic [3:0] k);
    if (exp_cyc.size() == 0) begin
      chk(1'b0, "unexpected event", int'(k), -1);
    end else begin
      int         c = exp_cyc.pop_front();
      logic [3:0] e = exp_kind.pop_front();
      string      t = exp_tag.pop_front();
      chk(k == e, {t, " event kind"}, int'(k), int'(e));
      chk(cyc == c, {t, " event cycle"}, cyc, c);
    end
  endtask

  logic need_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_code != NOP) observe(cmd_code);
      if (rf_need && !need_q) observe(NEED);
    end
    need_q <= rf_need;
  end

  task automatic pulse_req();
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
  endtask

  task automatic pulse_grant();
    seq_grant = 1'b1;
    @(negedge clk);
    seq_grant = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, g, k2, g2, k3, k4;
    rst_n = 1'b0; refresh_req = 1'b0; row_open = 1'b0; seq_grant = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_code == NOP, "R1 R9 cmd in reset", int'(cmd_code), int'(NOP));
    chk(!busy && !rf_need && !cmd_a10, "R1 flags in reset", int'({busy, rf_need, cmd_a10}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_code == NOP && !rf_need, "R1 after reset", int'(cmd_code), int'(NOP));

    // R3 / R7: manual request, no open row
    k = cyc + 1;
    expect_ev(k, NEED, "R3 manual need");
    pulse_req();
    chk(rf_need, "R3 need raised", int'(rf_need), 1);
    g = cyc + 1;
    expect_ev(g, AREF, "R7 direct refresh");
    pulse_grant();
    chk(busy, "R8 busy at refresh", int'(busy), 1);
    chk(!rf_need, "R5 need cleared", int'(rf_need), 0);
    wait_until(g + 2);
    pulse_req();          // R4: ignored while busy
    wait_until(g + 8);
    chk(busy, "R8 busy at window end", int'(busy), 1);
    @(negedge clk);
    chk(!busy, "R8 busy released", int'(busy), 0);
    chk(!rf_need, "R4 request during busy ignored", int'(rf_need), 0);
    pulse_grant();        // R5: grant with nothing pending
    chk(!busy && cmd_code == NOP, "R5 idle grant ignored", int'(busy), 0);

    // R6: open row closes first
    k2 = cyc + 1;
    expect_ev(k2, NEED, "R3 manual need 2");
    pulse_req();
    row_open = 1'b1;
    g2 = cyc + 1;
    expect_ev(g2, PRE, "R6 precharge first");
    expect_ev(g2 + 2, AREF, "R6 refresh after tRP");
    pulse_grant();
    chk(cmd_a10, "R6 a10 with precharge", int'(cmd_a10), 1);
    @(negedge clk);
    chk(cmd_code == NOP && !cmd_a10, "R6 nop gap", int'(cmd_code), int'(NOP));
    wait_until(g2 + 10);
    chk(busy, "R8 busy end of window", int'(busy), 1);
    @(negedge clk);
    chk(!busy, "R8 busy low after window", int'(busy), 0);
    row_open = 1'b0;

    // R2: timer expiry; R4: request while pending
    expect_ev(k2 + IVL, NEED, "R2 interval need");
    wait_until(k2 + IVL - 1);
    chk(!rf_need, "R2 not early", int'(rf_need), 0);
    @(negedge clk);
    chk(rf_need, "R2 on time", int'(rf_need), 1);
    pulse_req();          // R4: absorbed, no restart
    wait_until(k2 + IVL + 4);
    expect_ev(k2 + IVL + 5, AREF, "R5 granted refresh");
    pulse_grant();
    repeat (12) @(negedge clk);

    // R4: request coincident with expiry
    k3 = k2 + 2 * IVL;
    wait_until(k3 - 1);
    expect_ev(k3, NEED, "R4 single need");
    pulse_req();
    expect_ev(k3 + 2, AREF, "R4 single refresh");
    @(negedge clk);
    pulse_grant();
    repeat (12) @(negedge clk);
    chk(!rf_need && !busy, "R4 no second refresh", int'(rf_need), 0);

    // R3: early request restarts the interval
    k4 = k3 + 300;
    wait_until(k4 - 1);
    expect_ev(k4, NEED, "R3 early need");
    pulse_req();
    expect_ev(k4 + 1, AREF, "R7 early refresh");
    pulse_grant();
    expect_ev(k4 + IVL, NEED, "R3 restarted interval");
    wait_until(k4 + IVL - 1);
    chk(!rf_need, "R3 old schedule dropped", int'(rf_need), 0);
    @(negedge clk);
    chk(rf_need, "R3 new schedule", int'(rf_need), 1);
    expect_ev(k4 + IVL + 1, AREF, "R7 last refresh");
    pulse_grant();
    repeat (12) @(negedge clk);

    chk(exp_cyc.size() == 0, "scoreboard drained", exp_cyc.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule